// File: doc/BRIEF.md
# Frame-Count Periodic Interrupt Generator

This block counts display frames and raises a sticky flag once a programmed number of frames has gone by. Software uses it as a steady tick for work tied to the frame rate, such as scrolling text, stepping a progress bar, blinking icons or advancing a clock. For example, a 16-frame period at a 62.5 Hz frame rate gives one tick every 256 ms. The flag can be polled whether or not the interrupt is enabled. When the interrupt is enabled and given a nonzero priority level, the block also raises a request tagged with that level toward the interrupt controller.

The period is held in a 5-bit field that stores N−1. With the normal waveform one tick comes every N frames, so periods of 1 to 32 frames are possible. With the low-power waveform selected one tick comes every 2×N frames, so periods of 2 to 64 frames in steps of two are possible. Software clears the flag by writing a one to it. Servicing the interrupt clears it through the acknowledge input. All pins are plain control and status signals and carry no data stream, so no valid/ready handshake applies.

Top module: `frame_tick_irq`

## Requirements
- R1: After reset, `tick_flag` is 0, `irq_req` is 0, `irq_prio` is 0, the stored period field is 0 and the frame count is 0.
- R2: With `lowpwr_wave`=0 and period field P, `tick_flag` sets on the (P+1)-th `frame_start` pulse counted since the last restart or the last tick, and this repeats every P+1 pulses. P=0 ticks on every frame.
- R3: With `lowpwr_wave`=1 and period field P, the tick comes every 2×(P+1) pulses. P=31 gives 64 frames.
- R4: The flag sets on a tick whatever the values of `irq_en` and `irq_level`.
- R5: Once set, the flag holds until it is cleared. Further ticks keep it at 1.
- R6: A cycle with `irq_ack`=1 clears the flag.
- R7: A cycle with `clr_wr`=1 and `clr_data`=1 clears the flag. A write with `clr_data`=0 leaves it unchanged.
- R8: If a tick and a clear (ack or write-one) fall in the same cycle, the flag ends up set.
- R9: `irq_req` is 1 exactly when the flag is 1, `irq_en` is 1 and `irq_level` is nonzero. `irq_prio` equals `irq_level` while `irq_req` is 1 and is 0 otherwise.
- R10: A cycle with `period_wr`=1 loads `period_wdata` and restarts the frame count from zero. A `frame_start` in that same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse at each new frame |
| period_wr | input | 1 | Write strobe for the period field |
| period_wdata | input | 5 | Period field value, N−1 |
| lowpwr_wave | input | 1 | 1 selects the low-power waveform (period doubled) |
| irq_en | input | 1 | Interrupt enable |
| irq_level | input | 2 | Interrupt priority level (0 means off) |
| clr_wr | input | 1 | Software write strobe to the flag |
| clr_data | input | 1 | Data bit of the flag write (1 clears the flag) |
| irq_ack | input | 1 | Interrupt serviced, clears the flag |
| tick_flag | output | 1 | Sticky frame-count flag |
| irq_req | output | 1 | Interrupt request |
| irq_prio | output | 2 | Priority level that goes with the request |

## Verification
If the frame count goes wrong internally, the first symptom at the ports is the flag rising one or more frames early or late. This shows up within a single period, which is at most 64 frames. If the stored period or the low-power scaling goes wrong, the spacing between consecutive ticks changes, so the bench measures that spacing exactly at both ends of each range. A flag register that ignores set priority or clears on the wrong write shows up in the very cycle after the coincident or ignored stimulus, and the bench reads `tick_flag` there.

// File: rtl/fcirq_pkg.sv
package fcirq_pkg;
  localparam int PERIOD_W = 5;
  localparam int CNT_W    = PERIOD_W + 2;
  typedef logic [CNT_W-1:0] fcnt_t;

  // Frames per tick: field+1, doubled in low-power mode
  function automatic fcnt_t frames_per_tick(input logic [PERIOD_W-1:0] fld,
                                            input logic lp);
    fcnt_t n;
    n = fcnt_t'(fld) + fcnt_t'(1);
    return lp ? fcnt_t'(n << 1) : n;
  endfunction
endpackage

// File: rtl/fcirq_counter.sv
module fcirq_counter
  import fcirq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                period_wr,
  input  logic [PERIOD_W-1:0] period_wdata,
  input  logic                lowpwr_wave,
  output logic                tick
);
  logic [PERIOD_W-1:0] period_q;
  fcnt_t               cnt_q;
  fcnt_t               cnt_inc;
  fcnt_t               target;
  logic                wrap;

  assign target  = frames_per_tick(period_q, lowpwr_wave);
  assign cnt_inc = cnt_q + fcnt_t'(1);
  assign wrap    = (cnt_inc >= target);
  assign tick    = frame_start && !period_wr && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_q    <= '0;
    end else if (period_wr) begin
      period_q <= period_wdata;
      cnt_q    <= '0;
    end else if (frame_start) begin
      cnt_q <= wrap ? '0 : cnt_inc;
    end
  end

  // R10
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_wr |=> (cnt_q == '0));

  // R2
  wrap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/fcirq_flag.sv
module fcirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic irq_ack,
  input  logic clr_wr,
  input  logic clr_data,
  output logic flag
);
  logic clr;
  assign clr = irq_ack || (clr_wr && clr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (tick) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flag);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !tick) |=> !flag);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !irq_ack && !(clr_wr && clr_data)) |=> $stable(flag));
endmodule

// File: rtl/frame_tick_irq.sv
module frame_tick_irq
  import fcirq_pkg::*;
#(
  parameter int LEVEL_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               period_wr,
  input  logic [4:0]         period_wdata,
  input  logic               lowpwr_wave,
  input  logic               irq_en,
  input  logic [LEVEL_W-1:0] irq_level,
  input  logic               clr_wr,
  input  logic               clr_data,
  input  logic               irq_ack,
  output logic               tick_flag,
  output logic               irq_req,
  output logic [LEVEL_W-1:0] irq_prio
);
  logic tick;

  fcirq_counter u_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .period_wr    (period_wr),
    .period_wdata (period_wdata[PERIOD_W-1:0]),
    .lowpwr_wave  (lowpwr_wave),
    .tick         (tick)
  );

  fcirq_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .irq_ack  (irq_ack),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .flag     (tick_flag)
  );

  assign irq_req  = tick_flag && irq_en && (irq_level != '0);
  assign irq_prio = irq_req ? irq_level : '0;

  // R9
  req_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (tick_flag && irq_prio != '0));
endmodule

// File: tb/test_frame_tick_irq.sv
module test_frame_tick_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0, period_wr = 1'b0, lowpwr_wave = 1'b0;
  logic [4:0] period_wdata = '0;
  logic       irq_en = 1'b0, clr_wr = 1'b0, clr_data = 1'b0, irq_ack = 1'b0;
  logic [1:0] irq_level = '0;
  logic       tick_flag, irq_req;
  logic [1:0] irq_prio;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  frame_tick_irq i_frame_tick_irq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .period_wr(period_wr),
    .period_wdata(period_wdata), .lowpwr_wave(lowpwr_wave), .irq_en(irq_en),
    .irq_level(irq_level), .clr_wr(clr_wr), .clr_data(clr_data), .irq_ack(irq_ack),
    .tick_flag(tick_flag), .irq_req(irq_req), .irq_prio(irq_prio)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one-cycle pulses, driven at negedge, results read at the next negedge
  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_start = 1'b1;
      @(negedge clk) frame_start = 1'b0;
    end
  endtask

  task automatic set_period(input logic [4:0] p);
    @(negedge clk) begin period_wr = 1'b1; period_wdata = p; end
    @(negedge clk) period_wr = 1'b0;
  endtask

  task automatic ack_flag();
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 flag", tick_flag, 0);
    check("R1 req", irq_req, 0);
    check("R1 prio", irq_prio, 0);
    frames(1); // period field 0 after reset -> one frame
    check("R1 field0 tick", tick_flag, 1);
    ack_flag();
  endtask

  task automatic t_default();
    lowpwr_wave = 1'b0;
    set_period(5'd2);
    frames(2); check("R2 before 3rd", tick_flag, 0);
    frames(1); check("R2 on 3rd", tick_flag, 1);
    ack_flag(); check("R6 ack clears", tick_flag, 0);
    frames(2); check("R2 repeat before", tick_flag, 0);
    frames(1); check("R2 repeat on", tick_flag, 1);
    frames(3); check("R5 sticky", tick_flag, 1);
    ack_flag();
    set_period(5'd31);
    frames(31); check("R2 P31 before", tick_flag, 0);
    frames(1);  check("R2 P31 on 32", tick_flag, 1);
    ack_flag();
  endtask

  task automatic t_lowpwr();
    lowpwr_wave = 1'b1;
    set_period(5'd2);
    frames(5); check("R3 before 6", tick_flag, 0);
    frames(1); check("R3 on 6", tick_flag, 1);
    ack_flag();
    set_period(5'd0);
    frames(1); check("R3 P0 before 2", tick_flag, 0);
    frames(1); check("R3 P0 on 2", tick_flag, 1);
    ack_flag();
    set_period(5'd31);
    frames(63); check("R3 before 64", tick_flag, 0);
    frames(1);  check("R3 on 64", tick_flag, 1);
    ack_flag();
    lowpwr_wave = 1'b0;
  endtask

  task automatic t_irq();
    set_period(5'd0);
    irq_en = 1'b0; irq_level = 2'd3;
    frames(1);
    check("R4 flag w/o enable", tick_flag, 1);
    check("R9 req off", irq_req, 0);
    @(negedge clk) begin irq_en = 1'b1; irq_level = 2'd0; end
    #1 check("R9 level0 no req", irq_req, 0);
    @(negedge clk) irq_level = 2'd2;
    #1 check("R9 req on", irq_req, 1);
    check("R9 prio", irq_prio, 2);
    ack_flag();
    check("R9 req drops", irq_req, 0);
    check("R9 prio zero", irq_prio, 0);
    irq_en = 1'b0; irq_level = 2'd0;
  endtask

  task automatic t_w1c();
    set_period(5'd0);
    frames(1);
    @(negedge clk) begin clr_wr = 1'b1; clr_data = 1'b0; end
    @(negedge clk) clr_wr = 1'b0;
    check("R7 write0 ignored", tick_flag, 1);
    @(negedge clk) begin clr_wr = 1'b1; clr_data = 1'b1; end
    @(negedge clk) begin clr_wr = 1'b0; clr_data = 1'b0; end
    check("R7 write1 clears", tick_flag, 0);
  endtask

  task automatic t_collide();
    set_period(5'd1);
    frames(1);
    @(negedge clk) begin frame_start = 1'b1; irq_ack = 1'b1; end
    @(negedge clk) begin frame_start = 1'b0; irq_ack = 1'b0; end
    check("R8 set beats ack", tick_flag, 1);
    ack_flag();
    frames(1);
    @(negedge clk) begin frame_start = 1'b1; clr_wr = 1'b1; clr_data = 1'b1; end
    @(negedge clk) begin frame_start = 1'b0; clr_wr = 1'b0; clr_data = 1'b0; end
    check("R8 set beats w1c", tick_flag, 1);
    ack_flag();
  endtask

  task automatic t_restart();
    set_period(5'd2);
    frames(2);
    set_period(5'd2);
    frames(2); check("R10 restarted", tick_flag, 0);
    frames(1); check("R10 tick after restart", tick_flag, 1);
    ack_flag();
    frames(2);
    @(negedge clk) begin frame_start = 1'b1; period_wr = 1'b1; period_wdata = 5'd2; end
    @(negedge clk) begin frame_start = 1'b0; period_wr = 1'b0; end
    check("R10 coincident frame dropped", tick_flag, 0);
    frames(2); check("R10 count restarted", tick_flag, 0);
    frames(1); check("R10 third after write", tick_flag, 1);
    ack_flag();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default();
    t_lowpwr();
    t_irq();
    t_w1c();
    t_collide();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule